// File: doc/BRIEF.md
# Calibration Pulse Generator with Rate Scaling

This block turns a stream of signed real-power samples into a fast calibration pulse train. Every accepted sample is added to a private accumulator. One active-high pulse is issued each time the accumulator holds a full quantum. The quantum is short, so the pulse rate tracks instantaneous power and a frequency counter can calibrate a meter quickly.

A three-bit rate select picks how many calibration pulses stand for one pulse of the slow energy outputs. The quantum is the slow-output quantum divided by that multiple. Pulses have a nominal width. When pulses come fast, the width shrinks to half the measured period. One select code is a high-rate mode in which every pulse has a fixed, very short width. Samples below a no-load threshold, and negative samples, add nothing. The output stays low in reset.

Top module: `cal_pulse_gen`

## Requirements
- R1: While `rst_n` is low, `cal_pulse` is low and the accumulator is cleared.
- R2: `rate_sel` = {hi, mid, lo} selects the multiple M. Code 3'b100 gives 128, 3'b000 and 3'b101 give 64, 3'b001 and 3'b110 give 32, 3'b010 and 3'b111 give 16, and 3'b011 gives 2048. The pulse quantum is BASE_QUANTUM / M.
- R3: Each pulse removes exactly one quantum from the accumulator. Under a constant sample value S that divides the quantum Q, pulses repeat every Q/S cycles.
- R4: When the previous pulse-to-pulse period is at least 2*NOM_WIDTH cycles, or no previous period is known, a pulse lasts NOM_WIDTH cycles.
- R5: When that period P is below 2*NOM_WIDTH cycles, a pulse lasts P/2 cycles, rounded down, and never less than 1 cycle.
- R6: With code 3'b011 (high-rate mode), every pulse lasts HF_WIDTH cycles, whatever the rate.
- R7: A sample that is non-negative but below NOLOAD is not accumulated.
- R8: A negative sample is treated as zero and does not reduce the accumulator.
- R9: A change of `rate_sel` while a pulse is high does not alter that pulse. The new code is adopted in the first cycle with no pulse in progress, and it clears the accumulator.
- R10: No new pulse starts while one is high. Excess energy stays in the accumulator, which saturates instead of wrapping, and is paid out after the pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Power sample present this cycle |
| smp_power | input | PWR_W | Signed real-power sample |
| rate_sel | input | 3 | Rate multiple code {hi, mid, lo} |
| cal_pulse | output | 1 | Active-high calibration pulse |

## Verification
The embedded properties check, on every cycle, these rules:
- no pulse starts on top of another;
- a high run never exceeds the nominal width, or the short width in high-rate mode;
- the latched rate code holds still while a pulse is high;
- a negative or below-threshold sample leaves the accumulator unchanged.

Only the directed scenarios can show the exact pulse period for each of the eight select codes. They also show the half-period width rule settling at fast rates, the exact delay to the first pulse after a select change clears the accumulator, and the saturation and payout behaviour under overload.

// File: rtl/cal_pkg.sv
// Package: shared types and the rate-select decode for the calibration pulse
// generator. Assumes multiples are powers of two, expressed as shift counts.
package cal_pkg;

    typedef struct packed {
        logic [3:0] shift;   // log2 of the rate multiple
        logic       hf;      // high-rate mode with fixed short width
    } rate_t;

    // Map the three select bits {hi, mid, lo} to a multiple and a mode flag
    function automatic rate_t decode_rate(input logic [2:0] code);
        rate_t r;
        r.hf = 1'b0;
        case (code)
            3'b100:  r.shift = 4'd7;
            3'b000,
            3'b101:  r.shift = 4'd6;
            3'b001,
            3'b110:  r.shift = 4'd5;
            3'b010,
            3'b111:  r.shift = 4'd4;
            default: begin
                r.shift = 4'd11;
                r.hf    = 1'b1;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cal_rate_decode.sv
// Rate decode: turns the latched select code into a pulse quantum and the
// high-rate flag. Assumes BASE_QUANTUM is large enough that BASE>>11 >= 1.
module cal_rate_decode #(
    parameter int BASE_QUANTUM = 65536,
    parameter int ACC_W        = 18
) (
    input  logic [2:0]       code,
    output logic [ACC_W-1:0] quantum,
    output logic             hf
);
    import cal_pkg::*;

    rate_t r;

    // Combinational lookup of quantum and mode
    always_comb begin
        r       = decode_rate(code);
        quantum = ACC_W'(BASE_QUANTUM) >> r.shift;
        hf      = r.hf;
    end

endmodule

// File: rtl/cal_accum.sv
// Energy accumulator: adds clamped, threshold-gated samples and requests a
// pulse when a full quantum is held. Assumes quantum < 2**ACC_W. Saturates
// rather than wrapping when pulses are held off.
module cal_accum #(
    parameter int PWR_W  = 16,
    parameter int ACC_W  = 18,
    parameter int NOLOAD = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid,
    input  logic signed [PWR_W-1:0] sample,
    input  logic [ACC_W-1:0]        quantum,
    input  logic                    clear,
    input  logic                    ready,
    output logic                    fire
);
    localparam logic signed [PWR_W-1:0] NL_TH = PWR_W'(NOLOAD);

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] add;
    logic [ACC_W:0]   nxt;

    // Gate the sample: drop negatives and sub-threshold values
    always_comb begin
        add = '0;
        if (valid && !sample[PWR_W-1] && (sample >= NL_TH))
            add = ACC_W'(unsigned'(sample));
    end

    // Request a pulse when a quantum is available and the shaper is idle
    assign fire = ready && !clear && (acc >= quantum);

    // Next accumulator value before saturation
    assign nxt = {1'b0, acc} + {1'b0, add} - {1'b0, (fire ? quantum : '0)};

    // Accumulator register with clear and saturation
    always_ff @(posedge clk) begin
        if (!rst_n)         acc <= '0;
        else if (clear)     acc <= '0;
        else if (nxt[ACC_W]) acc <= '1;
        else                acc <= nxt[ACC_W-1:0];
    end

    a_r8_negative_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && sample[PWR_W-1] && !clear && !fire) |=> (acc == $past(acc)));

    a_r7_noload_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !sample[PWR_W-1] && (sample < NL_TH) && !clear && !fire)
        |=> (acc == $past(acc)));

endmodule

// File: rtl/cal_pulse_shaper.sv
// Pulse shaper: on each request it drives one active-high pulse. The width
// is nominal, half the last measured period at fast rates, or a fixed short
// width in high-rate mode. Assumes requests arrive only while idle.
module cal_pulse_shaper #(
    parameter int NOM_WIDTH = 40,
    parameter int HF_WIDTH  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic hf,
    input  logic restart,
    output logic pulse_o,
    output logic busy_o
);
    localparam int CAP = 2 * NOM_WIDTH;
    localparam int PW  = $clog2(CAP + 1);

    logic          active;
    logic [PW-1:0] pcnt;
    logic [PW-1:0] wcnt;
    logic [PW-1:0] width;
    logic [PW-1:0] half;
    logic [PW-1:0] run_len;

    // Pick the width for a pulse starting now
    always_comb begin
        half = pcnt >> 1;
        if (half == '0) half = PW'(1);
        if (hf)                  width = PW'(HF_WIDTH);
        else if (pcnt < PW'(CAP)) width = half;
        else                      width = PW'(NOM_WIDTH);
    end

    // Measure cycles between successive pulse starts, saturating at CAP
    always_ff @(posedge clk) begin
        if (!rst_n || restart) pcnt <= PW'(CAP);
        else if (fire)         pcnt <= PW'(1);
        else if (pcnt < PW'(CAP)) pcnt <= pcnt + PW'(1);
    end

    // Pulse state and remaining-width counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            wcnt   <= '0;
        end else if (fire) begin
            active <= 1'b1;
            wcnt   <= width - PW'(1);
        end else if (active) begin
            if (wcnt == '0) active <= 1'b0;
            else            wcnt   <= wcnt - PW'(1);
        end
    end

    assign pulse_o = active;
    assign busy_o  = active;

    // Checker: length of the current high run
    always_ff @(posedge clk) begin
        if (!rst_n)      run_len <= '0;
        else if (active) run_len <= run_len + PW'(1);
        else             run_len <= '0;
    end

    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> !active);

    a_r4_width_limit: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (run_len < PW'(NOM_WIDTH)));

    a_r6_hf_width: assert property (@(posedge clk) disable iff (!rst_n)
        (active && hf) |-> (run_len < PW'(HF_WIDTH)));

endmodule

// File: rtl/cal_pulse_gen.sv
// Calibration pulse generator top. Latches the rate code between pulses,
// clears the accumulator on a code change, and links the accumulator to the
// shaper. Assumes samples are real power in the same units as BASE_QUANTUM.
module cal_pulse_gen #(
    parameter int PWR_W        = 16,
    parameter int BASE_QUANTUM = 65536,
    parameter int NOM_WIDTH    = 40,
    parameter int HF_WIDTH     = 3,
    parameter int NOLOAD       = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic signed [PWR_W-1:0] smp_power,
    input  logic [2:0]              rate_sel,
    output logic                    cal_pulse
);
    localparam int QW    = $clog2(BASE_QUANTUM) + 1;
    localparam int ACC_W = ((QW > PWR_W) ? QW : PWR_W) + 2;

    logic [2:0]       sel_q;
    logic             apply;
    logic             busy;
    logic             fire;
    logic             hf;
    logic [ACC_W-1:0] quantum;

    assign apply = (rate_sel != sel_q) && !busy;

    // Adopt a new rate code only while no pulse is in progress
    always_ff @(posedge clk) begin
        if (!rst_n)     sel_q <= rate_sel;
        else if (apply) sel_q <= rate_sel;
    end

    cal_rate_decode #(.BASE_QUANTUM(BASE_QUANTUM), .ACC_W(ACC_W)) u_dec (
        .code    (sel_q),
        .quantum (quantum),
        .hf      (hf)
    );

    cal_accum #(.PWR_W(PWR_W), .ACC_W(ACC_W), .NOLOAD(NOLOAD)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (smp_valid),
        .sample  (smp_power),
        .quantum (quantum),
        .clear   (apply),
        .ready   (!busy),
        .fire    (fire)
    );

    cal_pulse_shaper #(.NOM_WIDTH(NOM_WIDTH), .HF_WIDTH(HF_WIDTH)) u_shp (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .hf      (hf),
        .restart (apply),
        .pulse_o (cal_pulse),
        .busy_o  (busy)
    );

    a_r9_code_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(sel_q));

endmodule

// File: tb/cal_pulse_gen_bench.sv
module cal_pulse_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PWR_W = 16;
    localparam int BASE  = 65536;
    localparam int NOM   = 40;
    localparam int HFW   = 3;
    localparam int NL    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic signed [PWR_W-1:0] smp_power = '0;
    logic [2:0] rate_sel = 3'b010;
    logic cal_pulse;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cal_pulse_gen #(.PWR_W(PWR_W), .BASE_QUANTUM(BASE), .NOM_WIDTH(NOM),
                    .HF_WIDTH(HFW), .NOLOAD(NL)) u_cal_pulse_gen (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .smp_power(smp_power), .rate_sel(rate_sel), .cal_pulse(cal_pulse));

    function automatic int multiple(input logic [2:0] c);
        case (c)
            3'b100: return 128;
            3'b000, 3'b101: return 64;
            3'b001, 3'b110: return 32;
            3'b010, 3'b111: return 16;
            default: return 2048;
        endcase
    endfunction

    task automatic check(input int act, input int exp, input string req);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_high(input int lim, output int n);
        n = 0;
        while (!cal_pulse && n < lim) begin @(negedge clk); n++; end
    endtask

    task automatic wait_low(input int lim, output int n);
        n = 0;
        while (cal_pulse && n < lim) begin @(negedge clk); n++; end
    endtask

    task automatic measure(output int w, output int p);
        int a, l;
        wait_low(5000, a);
        wait_high(5000, a);
        wait_low(5000, w);
        wait_high(5000, l);
        p = w + l;
    endtask

    task automatic switch_mode(input logic [2:0] code);
        int a;
        smp_power = '0;
        wait_low(5000, a);
        rate_sel = code ^ 3'b001;
        repeat (4) @(negedge clk);
        rate_sel = code;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        int hi = 0;
        smp_valid = 1'b1;
        smp_power = 16'sd30000;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (cal_pulse) hi++;
        end
        check(hi, 0, "R1 output low in reset");
        smp_power = '0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_decode;
        int w, p;
        for (int c = 0; c < 8; c++) begin
            int q = BASE / multiple(3'(c));
            switch_mode(3'(c));
            if (c == 3) begin
                smp_power = PWR_W'(4);
                measure(w, p); measure(w, p);
                check(p, q / 4, "R2 R3 period high-rate code");
                check(w, HFW, "R6 fixed short width");
            end else begin
                smp_power = PWR_W'(q / 128);
                measure(w, p); measure(w, p);
                check(p, 128, "R2 R3 period per code");
                check(w, NOM, "R4 nominal width");
            end
        end
    endtask

    task automatic t_half;
        int w, p;
        switch_mode(3'b010);
        smp_power = 16'sd64;
        repeat (1500) @(negedge clk);
        measure(w, p); measure(w, p);
        check(p, 64, "R5 period 64");
        check(w, 32, "R5 half width at 64");
        smp_power = 16'sd256;
        repeat (1500) @(negedge clk);
        measure(w, p); measure(w, p);
        check(p, 16, "R5 period 16");
        check(w, 8, "R5 half width at 16");
    endtask

    task automatic t_overload;
        int w, p;
        switch_mode(3'b010);
        smp_power = 16'sd4096;
        repeat (500) @(negedge clk);
        measure(w, p);
        check(w, 1, "R10 minimum width");
        check(p, 2, "R10 back-to-back spacing");
    endtask

    task automatic t_ignored(input logic signed [PWR_W-1:0] v, input string req);
        int hi = 0, n;
        switch_mode(3'b011);
        smp_power = v;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (cal_pulse) hi++;
        end
        check(hi, 0, req);
        smp_power = 16'sd4;
        wait_high(100, n);
        check(n, 9, req);
    endtask

    task automatic t_defer;
        int a, w, n;
        switch_mode(3'b010);
        smp_power = 16'sd32;
        wait_high(5000, a);
        wait_low(5000, a);
        wait_high(5000, a);
        repeat (5) @(negedge clk);
        rate_sel = 3'b011;
        smp_power = 16'sd4;
        wait_low(5000, w);
        check(w + 5, NOM, "R9 in-flight pulse kept");
        wait_high(100, n);
        check(n, 10, "R9 cleared accumulator delay");
        wait_low(100, w);
        check(w, HFW, "R9 new code width");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_decode();
        t_half();
        t_overload();
        t_ignored(16'sd3, "R7 sub-threshold ignored");
        t_ignored(-16'sd1000, "R8 negative clamped");
        t_defer();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule